// File: doc/BRIEF.md
# Open-Row Tracker and Access Classifier

This block tracks the open row of each bank of a DRAM device. Every bank has a row register and a valid bit. The block watches the command stream that is sent to the device and updates these records on every activate, single-bank precharge, all-bank precharge or refresh.

A lookup port takes the bank and row of a candidate request. In the same cycle it sorts the request into one of three classes:

- **Hit**: the bank is open on the requested row.
- **Empty**: the bank is closed.
- **Miss**: the bank is open on a different row.

For each class the block returns a nominal latency and the command steps the access needs. One saturating event counter per class records how often each class occurs. A scheduler or a performance monitor uses these outputs to weigh requests. The block does no scheduling of its own.

Top module: `row_tracker`

## Requirements
- R1: After reset every bank is closed and all three event counters read zero.
- R2: A valid request whose bank is open on the requested row gives class 1 (hit), latency T_CL, step mask 3'b001 (column only) and hit high.
- R3: A valid request to a closed bank gives class 2 (empty), latency T_RCD+T_CL and step mask 3'b011 (activate, column), with hit low.
- R4: A valid request to a bank open on a different row gives class 3 (miss), latency T_RP+T_RCD+T_CL and step mask 3'b111 (precharge, activate, column), with hit low.
- R5: Command code 1 (activate) opens bank cmd_bank on row cmd_row and leaves all other banks unchanged.
- R6: Command code 2 (precharge) closes only bank cmd_bank.
- R7: Command code 3 (precharge all) and code 4 (refresh) close every bank. Codes 0, 5, 6 and 7 change nothing.
- R8: A command and a request in the same cycle are classified against the state after that command is applied. An activate of the requested bank and row gives a hit.
- R9: With req_valid low, the class, latency, step mask and hit all read zero, and no counter changes.
- R10: Each valid request adds one to the counter of its class, one cycle later. A counter at its maximum value stays there.
- R11: cnt_clear zeroes all three counters on the next edge and takes priority over a count in the same cycle.
- R12: With the default timings of 6, 6 and 6, the latencies for hit, empty and miss are 6, 12 and 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| cmd_op | input | 3 | Observed command: 0 none, 1 activate, 2 precharge, 3 precharge all, 4 refresh |
| cmd_bank | input | BANK_W | Bank of the observed command |
| cmd_row | input | ROW_W | Row of an observed activate |
| cnt_clear | input | 1 | Clears the event counters |
| acc_class | output | 2 | 0 none, 1 hit, 2 empty, 3 miss |
| acc_lat | output | LAT_W | Nominal latency in cycles |
| acc_steps | output | 3 | {precharge, activate, column} steps needed |
| acc_hit | output | 1 | Request is a hit |
| cnt_hit | output | CNT_W | Hit event count |
| cnt_empty | output | CNT_W | Empty event count |
| cnt_miss | output | CNT_W | Miss event count |

## Verification
The bench first fills several banks with activates and probes them with rows that match and rows that differ. This separates the hit class from the miss class, and the closed banks give the empty class.

Single-bank precharges are mixed with precharge-all and refresh. This shows whether a close reaches one bank or all of them. Same-cycle activates and precharges on the probed bank, and also on a different bank, test that the lookup sees the new state.

A long run of hits drives a counter into saturation. Clears issued together with requests show that the clear wins.

// File: rtl/row_tracker.sv
module row_tracker #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int CNT_W     = 8,
  parameter int LAT_W     = 6,
  parameter int T_CL      = 6,
  parameter int T_RCD     = 6,
  parameter int T_RP      = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic              cnt_clear,
  output logic [1:0]        acc_class,
  output logic [LAT_W-1:0]  acc_lat,
  output logic [2:0]        acc_steps,
  output logic              acc_hit,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_empty,
  output logic [CNT_W-1:0]  cnt_miss
);
  localparam logic [2:0] OP_ACT = 3'd1, OP_PRE = 3'd2, OP_PREA = 3'd3, OP_REF = 3'd4;
  localparam logic [1:0] C_NONE = 2'd0, C_HIT = 2'd1, C_EMPTY = 2'd2, C_MISS = 2'd3;

  logic [ROW_W-1:0]     row_q   [NUM_BANKS];
  logic [ROW_W-1:0]     row_d   [NUM_BANKS];
  logic [NUM_BANKS-1:0] open_q, open_d;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wire sel = (cmd_bank == BANK_W'(b));
    always_comb begin
      row_d[b]  = row_q[b];
      open_d[b] = open_q[b];
      case (cmd_op)
        OP_ACT:          if (sel) begin open_d[b] = 1'b1; row_d[b] = cmd_row; end
        OP_PRE:          if (sel) open_d[b] = 1'b0;
        OP_PREA, OP_REF: open_d[b] = 1'b0;
        default: ;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else begin
        open_q[b] <= open_d[b];
        row_q[b]  <= row_d[b];
      end
    end
  end

  wire look_open = open_d[req_bank];
  wire look_same = (row_d[req_bank] == req_row);

  assign acc_class = !req_valid ? C_NONE  :
                     !look_open ? C_EMPTY :
                     look_same  ? C_HIT   : C_MISS;
  assign acc_hit   = (acc_class == C_HIT);

  always_comb begin
    case (acc_class)
      C_HIT:   begin acc_lat = LAT_W'(T_CL);              acc_steps = 3'b001; end
      C_EMPTY: begin acc_lat = LAT_W'(T_RCD + T_CL);      acc_steps = 3'b011; end
      C_MISS:  begin acc_lat = LAT_W'(T_RP + T_RCD + T_CL); acc_steps = 3'b111; end
      default: begin acc_lat = '0;                        acc_steps = 3'b000; end
    endcase
  end

  logic [CNT_W-1:0] cnt_q [3];
  for (genvar k = 0; k < 3; k++) begin : g_cnt
    wire bump = (acc_class == 2'(k + 1)) && (cnt_q[k] != {CNT_W{1'b1}});
    always_ff @(posedge clk) begin
      if (!rst_n || cnt_clear) cnt_q[k] <= '0;
      else if (bump)           cnt_q[k] <= cnt_q[k] + 1'b1;
    end
  end

  assign cnt_hit   = cnt_q[0];
  assign cnt_empty = cnt_q[1];
  assign cnt_miss  = cnt_q[2];
endmodule

// File: rtl/row_tracker_chk.sv
module row_tracker_chk #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int CNT_W  = 8,
  parameter int LAT_W  = 6,
  parameter int T_CL   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [ROW_W-1:0]  cmd_row,
  input logic              cnt_clear,
  input logic [1:0]        acc_class,
  input logic [LAT_W-1:0]  acc_lat,
  input logic [2:0]        acc_steps,
  input logic              acc_hit,
  input logic [CNT_W-1:0]  cnt_hit,
  input logic [CNT_W-1:0]  cnt_empty,
  input logic [CNT_W-1:0]  cnt_miss
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |-> acc_lat == LAT_W'(T_CL)); // R2
  AST_MISS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_class == 2'd3 |-> acc_steps == 3'b111 && !acc_hit); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> acc_class == 2'd0 && !acc_hit && acc_steps == 3'b000); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> cnt_hit == '0 && cnt_empty == '0 && cnt_miss == '0); // R11
  AST_HIT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_hit == CMAX && !cnt_clear |=> cnt_hit == CMAX); // R10
  AST_ALL_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_op) == 3'd3 || $past(cmd_op) == 3'd4) && cmd_op == 3'd0 && req_valid
    |-> acc_class == 2'd2); // R7
  AST_ACT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && cmd_op == 3'd1 && cmd_bank == req_bank && cmd_row == req_row |-> acc_hit); // R8
endmodule

bind row_tracker row_tracker_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .LAT_W(LAT_W), .T_CL(T_CL)
) u_chk (.*);

// File: tb/row_tracker_tb.sv
`timescale 1ns/1ps
module row_tracker_tb;
  localparam int NB = 8, RW = 14, CW = 8, LW = 6, BW = 3;
  localparam int CMAX = 255;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, cnt_clear = 1'b0;
  logic [BW-1:0] req_bank = '0, cmd_bank = '0;
  logic [RW-1:0] req_row = '0, cmd_row = '0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] acc_class;
  logic [LW-1:0] acc_lat;
  logic [2:0] acc_steps;
  logic acc_hit;
  logic [CW-1:0] cnt_hit, cnt_empty, cnt_miss;

  always #4 clk = ~clk;

  row_tracker u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit mvld [NB];
  int mrow [NB];
  int mcnt [3];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input int bank, input int row, input int op,
                      input int cb, input int cr, input bit clr, input string note);
    int ec, el, es;
    string t;
    @(negedge clk);
    req_valid = v; req_bank = BW'(bank); req_row = RW'(row);
    cmd_op = 3'(op); cmd_bank = BW'(cb); cmd_row = RW'(cr); cnt_clear = clr;
    #1;
    case (op)
      1: begin mvld[cb] = 1'b1; mrow[cb] = cr; end
      2: mvld[cb] = 1'b0;
      3, 4: foreach (mvld[i]) mvld[i] = 1'b0;
      default: ;
    endcase
    if (!v)                    begin ec = 0; el = 0;  es = 0; t = "R9"; end
    else if (!mvld[bank])      begin ec = 2; el = 12; es = 3; t = "R3/R12"; end
    else if (mrow[bank] == row) begin ec = 1; el = 6;  es = 1; t = "R2/R12"; end
    else                       begin ec = 3; el = 18; es = 7; t = "R4/R12"; end
    t = {t, " ", note};
    chk(acc_class == 2'(ec), {t, " class"}, acc_class, ec);
    chk(acc_lat == LW'(el), {t, " latency"}, acc_lat, el);
    chk(acc_steps == 3'(es), {t, " steps"}, acc_steps, es);
    chk(acc_hit == (ec == 1), {t, " hit"}, acc_hit, ec == 1);
    chk(cnt_hit == CW'(mcnt[0]), "R10 hit counter", cnt_hit, mcnt[0]);
    chk(cnt_empty == CW'(mcnt[1]), "R10 empty counter", cnt_empty, mcnt[1]);
    chk(cnt_miss == CW'(mcnt[2]), "R10 miss counter", cnt_miss, mcnt[2]);
    if (clr) foreach (mcnt[i]) mcnt[i] = 0;
    else if (ec != 0 && mcnt[ec-1] < CMAX) mcnt[ec-1]++;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mvld[i]) begin mvld[i] = 1'b0; mrow[i] = 0; end
    foreach (mcnt[i]) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: all banks closed after reset, counters zero
    for (int b = 0; b < NB; b++) step(1, b, 5, 0, 0, 0, 0, "R1 reset empty");
    step(0, 0, 0, 0, 0, 0, 1, "R11 clear");
    // R5: open banks one by one, other banks untouched
    step(0, 0, 0, 1, 2, 100, 0, "R5 act");
    step(1, 2, 100, 0, 0, 0, 0, "R5 hit");
    step(1, 3, 100, 0, 0, 0, 0, "R5 other bank empty");
    step(0, 0, 0, 1, 5, 16383, 0, "R5 act top row");
    step(1, 5, 16383, 0, 0, 0, 0, "R5 top row hit");
    step(1, 5, 0, 0, 0, 0, 0, "R4 miss");
    step(1, 2, 101, 0, 0, 0, 0, "R4 miss");
    // R8: same-cycle bypass
    step(1, 2, 77, 1, 2, 77, 0, "R8 act bypass");
    step(1, 5, 16383, 2, 5, 0, 0, "R8 pre bypass");
    step(1, 6, 9, 1, 7, 9, 0, "R8 act other bank");
    // R6: single precharge closes one bank
    step(0, 0, 0, 1, 0, 1, 0, "R6 act");
    step(0, 0, 0, 2, 2, 0, 0, "R6 pre");
    step(1, 2, 77, 0, 0, 0, 0, "R6 closed");
    step(1, 0, 1, 0, 0, 0, 0, "R6 still open");
    step(1, 7, 9, 0, 0, 0, 0, "R6 still open");
    // R7: precharge all, refresh, unused codes
    step(0, 0, 0, 3, 0, 0, 0, "R7 prea");
    for (int b = 0; b < NB; b++) step(1, b, 1, 0, 0, 0, 0, "R7 all closed");
    for (int b = 0; b < 4; b++) step(0, 0, 0, 1, b, b + 10, 0, "R7 reopen");
    step(1, 1, 11, 4, 0, 0, 0, "R7 refresh bypass");
    step(1, 3, 13, 0, 0, 0, 0, "R7 refresh closed");
    step(0, 0, 0, 1, 4, 40, 0, "R7 act");
    for (int op = 5; op < 8; op++) step(1, 4, 40, op, 4, 3, 0, "R7 unused code");
    step(1, 4, 41, 0, 0, 0, 0, "R7 unused kept row");
    // R9: idle cycles do not count
    for (int k = 0; k < 3; k++) step(0, 4, 40, 0, 0, 0, 0, "R9 idle");
    // R11: clear wins over a same-cycle count
    step(1, 4, 40, 0, 0, 0, 1, "R11 clear priority");
    step(1, 4, 40, 0, 0, 0, 0, "R11 after clear");
    // R10: saturation
    for (int k = 0; k < 300; k++) step(1, 4, 40, 0, 0, 0, 0, "R10 saturate");
    step(1, 4, 0, 0, 0, 0, 0, "R10 miss while hit full");
    step(0, 0, 0, 0, 0, 0, 1, "R11 clear full");
    step(0, 0, 0, 0, 0, 0, 0, "R11 zero");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule